// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the register file of a PCI host bridge. A processor reaches it through a simple memory-mapped slave port. Each access is either 4 or 8 bytes wide, and every register behind the port is 64 bits wide. A 4-byte access works on one half of a register, and one address bit chooses which half. The file holds these registers:

- an arbitration mask
- a status/control word
- an error-configuration word
- ten window base/mask registers

It also answers a few read-only locations:

- a fixed function-class code
- a bus-number echo
- an error status that always reads zero

Some locations accept writes and discard them. Any other offset is unmapped. How the block answers an unmapped access depends on a hard-fail enable bit in the status/control word. With the bit set, the access returns a decode error. With the bit clear, reads return all ones and writes are dropped, and both report OK. The response is registered and comes back one cycle after the strobe.

Top module: `pcib_csr_file`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle with `req_rd` or `req_wr` high, and low after cycles with neither strobe. When both strobes are high together, the access is a write.
- R2: `req_addr` is a 32-bit-unit address, so the byte offset is `req_addr*4`. The register is picked by `req_addr[ADDR_W-3:1]`, which is the byte offset with bits 2:0 cleared. `req_addr[0]`, which is byte-offset bit 2, picks only the half.
- R3: A 4-byte read (`req_wide=0`) returns the upper register half when byte-offset bit 2 is set, and the lower half otherwise. The half appears in `rsp_rdata[31:0]`, and `rsp_rdata[63:32]` reads zero.
- R4: A 4-byte write takes `req_wdata[31:0]` into the selected half and leaves the other half unchanged. An 8-byte write (`req_wide=1`) replaces all 64 bits.
- R5: The three read-only locations read as follows:
  - byte offset 0x008 reads 0x0000000006000005;
  - byte offset 0x058 reads `bus_num` in bits 7:0 and again in bits 15:8, with zero above;
  - byte offset 0x688 reads zero.
  Writes to these three locations are treated as unmapped.
- R6: The arbitration mask (0x080), status/control (0x108) and error configuration (0x680) are read/write and return what was written.
- R7: Byte offsets 0x200 to 0x24F are ten independent read/write registers, and register k sits at 0x200+8k.
- R8: Writes to byte offsets 0x000, 0x300 and 0x308 report OK and change no state, even with hard-fail set. Reads of these offsets are unmapped.
- R9: With status/control bit 5 (hard-fail enable) set, an unmapped access sets `rsp_err=1`, returns `rsp_rdata=0`, and changes no state.
- R10: With hard-fail clear, an unmapped read returns all ones, limited to bits 31:0 for a 4-byte read, and reports OK. An unmapped write reports OK and is dropped.
- R11: Reset clears all registers, `rsp_valid`, `rsp_err` and `rsp_rdata`. A write response carries `rsp_rdata=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_num | input | BUS_W | Static bus number echoed at 0x058 |
| req_addr | input | ADDR_W-2 | Access address in 32-bit units |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_wdata | input | 64 | Write data (bits 31:0 for 4-byte writes) |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | 1 = decode error, 0 = OK |

## Verification
The hardest state to reach from the ports is the combination of the hard-fail mode with the locations that are not uniformly mapped. These are offsets that accept writes but not reads, or reads but not writes. The bench first turns hard-fail on through an ordinary write to status/control. It then walks these offsets in both directions and checks, in the same mode, that the discarded-write offsets still answer OK. It also overwrites status/control through its upper half alone and shows that the lower half, and so hard-fail, survives. A mid-run reset, followed by an unmapped read, shows that reset returns the block to the all-ones answer.

// File: rtl/pcib_csr_pkg.sv
// Package: shared types and constants for the host bridge register file.
// Assumes 64-bit registers accessed as 4- or 8-byte quantities.
package pcib_csr_pkg;

    // What a decoded word address refers to
    typedef enum logic [3:0] {
        SEL_NONE,    // unmapped
        SEL_DROP,    // write accepted and discarded
        SEL_CLASS,   // constant function class
        SEL_BUSNUM,  // bus number echo
        SEL_ZERO,    // error status, reads zero
        SEL_ARB,
        SEL_STAT,
        SEL_WIN,
        SEL_ERRCFG
    } csr_sel_e;

    localparam logic [63:0] FUNC_CLASS_VAL = 64'h0000_0000_0600_0005;

endpackage

// File: rtl/pcib_csr_decode.sv
// Module: address decoder. Maps a 64-bit word index to a register selector,
// separately for reads and writes, and gives the window array index.
// Assumes ADDR_W >= 12 so every fixed offset is reachable.
module pcib_csr_decode
    import pcib_csr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int N_WIN  = 10,
    localparam int WORD_W = ADDR_W - 3,
    localparam int WIN_IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic [WORD_W-1:0]    word,
    input  logic                 is_wr,
    output csr_sel_e             sel,
    output logic [WIN_IDX_W-1:0] win_idx
);
    localparam logic [WORD_W-1:0] W_ID      = WORD_W'(0);
    localparam logic [WORD_W-1:0] W_CLASS   = WORD_W'(1);
    localparam logic [WORD_W-1:0] W_BUS     = WORD_W'(11);
    localparam logic [WORD_W-1:0] W_ARB     = WORD_W'(16);
    localparam logic [WORD_W-1:0] W_STAT    = WORD_W'(33);
    localparam logic [WORD_W-1:0] W_WIN0    = WORD_W'(64);
    localparam logic [WORD_W-1:0] W_IBASE   = WORD_W'(96);
    localparam logic [WORD_W-1:0] W_IMASK   = WORD_W'(97);
    localparam logic [WORD_W-1:0] W_ERRCFG  = WORD_W'(208);
    localparam logic [WORD_W-1:0] W_ERRSTAT = WORD_W'(209);

    logic [WORD_W-1:0] rel;
    logic              win_hit;

    // Window range check and relative index
    always_comb begin
        rel     = word - W_WIN0;
        win_hit = (word >= W_WIN0) && (rel < WORD_W'(N_WIN));
        win_idx = rel[WIN_IDX_W-1:0];
    end

    // Selector: read and write maps differ for constant and discard slots
    always_comb begin
        sel = SEL_NONE;
        if (win_hit) begin
            sel = SEL_WIN;
        end else begin
            case (word)
                W_ARB:     sel = SEL_ARB;
                W_STAT:    sel = SEL_STAT;
                W_ERRCFG:  sel = SEL_ERRCFG;
                W_CLASS:   sel = is_wr ? SEL_NONE : SEL_CLASS;
                W_BUS:     sel = is_wr ? SEL_NONE : SEL_BUSNUM;
                W_ERRSTAT: sel = is_wr ? SEL_NONE : SEL_ZERO;
                W_ID, W_IBASE, W_IMASK: sel = is_wr ? SEL_DROP : SEL_NONE;
                default:   sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pcib_csr_reg64.sv
// Module: one 64-bit register with half-word write merge.
// Assumes a 4-byte write carries its data in wdata[31:0].
module pcib_csr_reg64 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wide,
    input  logic        upper,
    input  logic [63:0] wdata,
    output logic [63:0] q
);
    // Update whole register or selected half; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            if (wide) begin
                q <= wdata;
            end else if (upper) begin
                q[63:32] <= wdata[31:0];
            end else begin
                q[31:0] <= wdata[31:0];
            end
        end
    end

    assert_keep_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wide && upper) |=> (q[31:0] == $past(q[31:0])));
    assert_keep_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wide && !upper) |=> (q[63:32] == $past(q[63:32])));
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/pcib_csr_resp.sv
// Module: read-data formation and registered response.
// Assumes the selector and register values are valid in the strobe cycle.
module pcib_csr_resp
    import pcib_csr_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access,
    input  logic             is_wr,
    input  csr_sel_e         sel,
    input  logic             wide,
    input  logic             upper,
    input  logic             hf_en,
    input  logic [BUS_W-1:0] bus_num,
    input  logic [63:0]      arb_q,
    input  logic [63:0]      stat_q,
    input  logic [63:0]      errcfg_q,
    input  logic [63:0]      win_q,
    output logic             rsp_valid,
    output logic [63:0]      rsp_rdata,
    output logic             rsp_err
);
    logic [63:0] raw;
    logic [63:0] shaped;
    logic        unmapped;

    // Pick the 64-bit source value for the access
    always_comb begin
        raw = '0;
        case (sel)
            SEL_CLASS:  raw = FUNC_CLASS_VAL;
            SEL_BUSNUM: begin
                raw[BUS_W-1:0]       = bus_num;
                raw[2*BUS_W-1:BUS_W] = bus_num;
            end
            SEL_ARB:    raw = arb_q;
            SEL_STAT:   raw = stat_q;
            SEL_ERRCFG: raw = errcfg_q;
            SEL_WIN:    raw = win_q;
            SEL_NONE:   raw = hf_en ? '0 : '1;
            default:    raw = '0;
        endcase
    end

    // Narrow to the selected half for 4-byte reads; writes return zero
    always_comb begin
        unmapped = (sel == SEL_NONE);
        if (is_wr)     shaped = '0;
        else if (wide) shaped = raw;
        else           shaped = {32'h0, upper ? raw[63:32] : raw[31:0]};
    end

    // Register the response one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= access;
            if (access) begin
                rsp_rdata <= shaped;
                rsp_err   <= unmapped && hf_en;
            end
        end
    end

    assert_err_needs_hf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !hf_en) |=> !rsp_err);
endmodule

// File: rtl/pcib_csr_file.sv
// Module: host bridge register file top. Decodes the slave port, holds the
// read/write registers, and forms a registered response with hard-fail rule.
// Assumes bus_num is static and accesses are 4 or 8 bytes.
module pcib_csr_file
    import pcib_csr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BUS_W  = 8,
    parameter int N_WIN  = 10,
    parameter int HF_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_num,
    input  logic [ADDR_W-3:0] req_addr,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              req_wide,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err
);
    localparam int WORD_W    = ADDR_W - 3;
    localparam int WIN_IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1;

    logic [WORD_W-1:0]    word;
    logic                 upper;
    logic                 access;
    csr_sel_e             sel;
    logic [WIN_IDX_W-1:0] win_idx;
    logic [63:0]          arb_q, stat_q, errcfg_q, win_rd;
    logic [63:0]          win_q [N_WIN];
    logic                 hf_en;

    // Split the address into word index and half select
    always_comb begin
        word   = req_addr[ADDR_W-3:1];
        upper  = req_addr[0];
        access = req_rd || req_wr;
        hf_en  = stat_q[HF_BIT];
    end

    pcib_csr_decode #(.ADDR_W(ADDR_W), .N_WIN(N_WIN)) u_decode (
        .word(word), .is_wr(req_wr), .sel(sel), .win_idx(win_idx)
    );

    pcib_csr_reg64 u_arb (
        .clk(clk), .rst_n(rst_n), .wr_en(req_wr && sel == SEL_ARB),
        .wide(req_wide), .upper(upper), .wdata(req_wdata), .q(arb_q)
    );
    pcib_csr_reg64 u_stat (
        .clk(clk), .rst_n(rst_n), .wr_en(req_wr && sel == SEL_STAT),
        .wide(req_wide), .upper(upper), .wdata(req_wdata), .q(stat_q)
    );
    pcib_csr_reg64 u_errcfg (
        .clk(clk), .rst_n(rst_n), .wr_en(req_wr && sel == SEL_ERRCFG),
        .wide(req_wide), .upper(upper), .wdata(req_wdata), .q(errcfg_q)
    );

    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        pcib_csr_reg64 u_win (
            .clk(clk), .rst_n(rst_n),
            .wr_en(req_wr && sel == SEL_WIN && win_idx == WIN_IDX_W'(i)),
            .wide(req_wide), .upper(upper), .wdata(req_wdata), .q(win_q[i])
        );
    end

    // Select the addressed window entry for reads
    always_comb begin
        win_rd = '0;
        for (int i = 0; i < N_WIN; i++) begin
            if (win_idx == WIN_IDX_W'(i)) win_rd = win_q[i];
        end
    end

    pcib_csr_resp #(.BUS_W(BUS_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .access(access), .is_wr(req_wr), .sel(sel),
        .wide(req_wide), .upper(upper), .hf_en(hf_en), .bus_num(bus_num),
        .arb_q(arb_q), .stat_q(stat_q), .errcfg_q(errcfg_q), .win_q(win_rd),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> rsp_valid);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !access |=> !rsp_valid);
    assert_half_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && !req_wide) |=> (rsp_rdata[63:32] == 32'h0));
    assert_class_const_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && !req_wr && req_wide && sel == SEL_CLASS)
        |=> (rsp_rdata == FUNC_CLASS_VAL && !rsp_err));
    assert_hardfail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (access && sel == SEL_NONE && hf_en) |=> (rsp_err && rsp_rdata == 64'h0));
    assert_soft_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && !req_wr && req_wide && sel == SEL_NONE && !hf_en)
        |=> (rsp_rdata == '1 && !rsp_err));
endmodule

// File: tb/pcib_csr_file_bench.sv
module pcib_csr_file_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        wide;
        logic [12:0] addr;   // byte offset
        logic [63:0] wdata;
        logic        err;
        logic [63:0] rdata;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b1,13'h008,64'h0,1'b0,64'h6000005,4'd5},            // R5
        '{1'b1,1'b0,1'b0,13'h00C,64'h0,1'b0,64'h0,4'd3},                  // R3
        '{1'b1,1'b0,1'b1,13'h058,64'h0,1'b0,64'h2A2A,4'd5},               // R5
        '{1'b0,1'b1,1'b1,13'h080,64'h1122334455667788,1'b0,64'h0,4'd6},   // R6
        '{1'b1,1'b0,1'b1,13'h080,64'h0,1'b0,64'h1122334455667788,4'd6},   // R6
        '{1'b0,1'b1,1'b0,13'h084,64'h00000000AABBCCDD,1'b0,64'h0,4'd4},   // R4
        '{1'b1,1'b0,1'b1,13'h080,64'h0,1'b0,64'hAABBCCDD55667788,4'd4},   // R4
        '{1'b0,1'b1,1'b0,13'h080,64'hFFFF000001020304,1'b0,64'h0,4'd4},   // R4
        '{1'b1,1'b0,1'b1,13'h080,64'h0,1'b0,64'hAABBCCDD01020304,4'd4},   // R4
        '{1'b1,1'b0,1'b0,13'h084,64'h0,1'b0,64'hAABBCCDD,4'd3},           // R3
        '{1'b1,1'b0,1'b0,13'h080,64'h0,1'b0,64'h01020304,4'd2},           // R2
        '{1'b0,1'b1,1'b1,13'h200,64'h000000F800000001,1'b0,64'h0,4'd7},   // R7
        '{1'b0,1'b1,1'b1,13'h248,64'h000000000000E000,1'b0,64'h0,4'd7},   // R7
        '{1'b1,1'b0,1'b1,13'h200,64'h0,1'b0,64'h000000F800000001,4'd7},   // R7
        '{1'b1,1'b0,1'b1,13'h248,64'h0,1'b0,64'hE000,4'd7},               // R7
        '{1'b1,1'b0,1'b1,13'h208,64'h0,1'b0,64'h0,4'd7},                  // R7
        '{1'b1,1'b0,1'b1,13'h250,64'h0,1'b0,ONES,4'd10},                  // R10
        '{1'b1,1'b0,1'b0,13'h254,64'h0,1'b0,64'hFFFFFFFF,4'd10},          // R10
        '{1'b0,1'b1,1'b1,13'h300,64'h123,1'b0,64'h0,4'd8},                // R8
        '{1'b1,1'b0,1'b1,13'h300,64'h0,1'b0,ONES,4'd8},                   // R8
        '{1'b0,1'b1,1'b1,13'h008,64'h5,1'b0,64'h0,4'd10},                 // R10
        '{1'b1,1'b0,1'b1,13'h008,64'h0,1'b0,64'h6000005,4'd5},            // R5
        '{1'b0,1'b1,1'b1,13'h680,64'hDEAD,1'b0,64'h0,4'd6},               // R6
        '{1'b1,1'b0,1'b1,13'h680,64'h0,1'b0,64'hDEAD,4'd6},               // R6
        '{1'b1,1'b0,1'b1,13'h688,64'h0,1'b0,64'h0,4'd5},                  // R5
        '{1'b0,1'b1,1'b1,13'h688,64'h1,1'b0,64'h0,4'd10},                 // R10
        '{1'b0,1'b1,1'b1,13'h108,64'h20,1'b0,64'h0,4'd9},                 // R9
        '{1'b1,1'b0,1'b1,13'h108,64'h0,1'b0,64'h20,4'd6},                 // R6
        '{1'b1,1'b0,1'b1,13'h250,64'h0,1'b1,64'h0,4'd9},                  // R9
        '{1'b0,1'b1,1'b1,13'h1000,64'h77,1'b1,64'h0,4'd9},                // R9
        '{1'b0,1'b1,1'b1,13'h000,64'h1,1'b0,64'h0,4'd8},                  // R8
        '{1'b1,1'b0,1'b1,13'h000,64'h0,1'b1,64'h0,4'd8},                  // R8
        '{1'b1,1'b0,1'b0,13'h254,64'h0,1'b1,64'h0,4'd9},                  // R9
        '{1'b0,1'b1,1'b1,13'h688,64'h1,1'b1,64'h0,4'd9},                  // R9
        '{1'b0,1'b1,1'b0,13'h10C,64'h0,1'b0,64'h0,4'd4},                  // R4
        '{1'b1,1'b0,1'b1,13'h108,64'h0,1'b0,64'h20,4'd4}                  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_num = 8'h2A;
    logic [10:0] req_addr = '0;
    logic        req_rd = 1'b0, req_wr = 1'b0, req_wide = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    int          total = 0, fails = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcib_csr_file u_pcib_csr_file (
        .clk(clk), .rst_n(rst_n), .bus_num(bus_num), .req_addr(req_addr),
        .req_rd(req_rd), .req_wr(req_wr), .req_wide(req_wide),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err)
    );

    task automatic check(string tag, logic [65:0] got, logic [65:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // One access: drive at a falling edge, sample at the next falling edge
    task automatic op(logic rd, logic wr, logic wide, logic [12:0] addr,
                      logic [63:0] wd);
        @(negedge clk);
        req_rd = rd; req_wr = wr; req_wide = wide;
        req_addr = addr[12:2]; req_wdata = wd;
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state of the response
        check("R11 reset response", {rsp_valid, rsp_err, rsp_rdata}, 66'h0);
        rst_n = 1'b1;
        op(1, 0, 1, 13'h080, 0);
        check("R11 arb after reset", {rsp_valid, rsp_err, rsp_rdata}, {2'b10, 64'h0});
        @(negedge clk);
        // R1: no strobe, no response
        check("R1 idle", {65'h0, rsp_valid}, 66'h0);

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].rd, VECS[i].wr, VECS[i].wide, VECS[i].addr, VECS[i].wdata);
            check($sformatf("R%0d vector %0d", VECS[i].req, i),
                  {rsp_valid, rsp_err, rsp_rdata}, {1'b1, VECS[i].err, VECS[i].rdata});
        end

        // R1: both strobes act as a write
        op(1, 1, 1, 13'h680, 64'h55);
        check("R1 both strobes", {rsp_valid, rsp_err, rsp_rdata}, {2'b10, 64'h0});
        op(1, 0, 1, 13'h680, 0);
        check("R1 write took effect", {rsp_valid, rsp_err, rsp_rdata}, {2'b10, 64'h55});

        // R7: all windows independent
        for (int k = 0; k < 10; k++)
            op(0, 1, 1, 13'(13'h200 + 8*k), 64'h1000_0000_0000 + 64'(k * 257));
        for (int k = 0; k < 10; k++) begin
            op(1, 0, 1, 13'(13'h200 + 8*k), 0);
            check($sformatf("R7 window %0d", k), {rsp_valid, rsp_err, rsp_rdata},
                  {2'b10, 64'h1000_0000_0000 + 64'(k * 257)});
        end

        // R11: mid-run reset clears registers and hard-fail
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 mid reset response", {rsp_valid, rsp_err, rsp_rdata}, 66'h0);
        rst_n = 1'b1;
        op(1, 0, 1, 13'h108, 0);
        check("R11 stat cleared", {rsp_valid, rsp_err, rsp_rdata}, {2'b10, 64'h0});
        op(1, 0, 1, 13'h218, 0);
        check("R11 window cleared", {rsp_valid, rsp_err, rsp_rdata}, {2'b10, 64'h0});
        op(1, 0, 1, 13'h250, 0);
        check("R10 after reset", {rsp_valid, rsp_err, rsp_rdata}, {2'b10, ONES});
        finish_run();
    end
endmodule